// File: doc/BRIEF.md
# PWM Counter Event Router

This block sits beside a PWM generator and watches its counter. On every cycle in which the counter takes a new value, it decides which of six counter events are true. The events are: the counter reached zero, the counter reached the load value, and the counter matched comparator A or comparator B, each of those matches split by count direction. A single 32-bit enable register picks which events raise an interrupt request and which events fire a one-cycle conversion trigger for an ADC. The two selections are independent of each other.

Software reaches the enable register through a small register port with write and read strobes, an address and 32-bit data. Both outputs are registered pulses. A downstream status latch can capture the interrupt request, and an ADC sequencer can consume the trigger directly. The trigger does not say which event caused it.

Top module: `pwm_evt_route`

## Requirements
- R1: After reset the enable register reads 0x00000000, and `irq_pulse`, `adc_trig` and `rd_data` are all 0.
- R2: The enable register answers at address 0x044. A read returns only bits 13:8 and 5:0. Bits 7:6 and 31:14 read as zero whatever was written to them, so writing 0xFFFFFFFF and reading back gives 0x00003F3F.
- R3: Event bit positions: zero is bit 0 and load is bit 1 (interrupt enables), with the matching trigger enables at bits 8 and 9. A step with `cnt == 0` fires the zero event. A step with `cnt == load_val` fires the load event.
- R4: The comparator events depend on direction (`cnt_dir` = 1 means counting up). A-up is bit 2/10, A-down is bit 3/11, B-up is bit 4/12 and B-down is bit 5/13. Each fires only when `cnt` equals that comparator and the direction matches.
- R5: `adc_trig` is high for exactly the one cycle after each clock edge where at least one trigger-enabled event is true. Several coincident events give a single one-cycle pulse.
- R6: `irq_pulse` is high for the one cycle after each clock edge where at least one interrupt-enabled event is true. It is selected independently of `adc_trig`.
- R7: With `cnt_step` low, no event fires, whatever the counter and compare values are.
- R8: A write to any address other than 0x044 leaves the register unchanged. `rd_data` is zero in the cycle after a read of another address, and in the cycle after no read at all.
- R9: A write takes effect from the next clock edge. An event sampled at the same edge as the write uses the old enables.
- R10: A read returns the register value before any write at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| cnt_step | input | 1 | Counter took a new value this cycle |
| cnt_dir | input | 1 | 1 = counting up, 0 = counting down |
| cnt | input | CNT_W | Counter value |
| load_val | input | CNT_W | Counter load (period) value |
| cmpa_val | input | CNT_W | Comparator A value |
| cmpb_val | input | CNT_W | Comparator B value |
| irq_pulse | output | 1 | Interrupt request pulse |
| adc_trig | output | 1 | ADC trigger pulse |

## Verification
All three results arrive exactly one clock edge after their cause. `irq_pulse` and `adc_trig` follow the counter inputs sampled at an edge, and `rd_data` follows the read strobe at that edge. The bench drives inputs on the falling edge. It computes the expected outputs from those inputs and from its own copy of the enables as they were before the edge. It then compares all three outputs at the next falling edge, after updating its copy with any write. Same-edge write/event and write/read collisions are driven on purpose so that this one-edge ordering is checked.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
   localparam int REG_W   = 32;
   localparam int NUM_CMP = 2;
   localparam int NUM_EVT = 2 + 2 * NUM_CMP;
   localparam int IRQ_LSB = 0;
   localparam int TRG_LSB = 8;

   typedef enum int unsigned {
      EV_ZERO = 0,
      EV_LOAD = 1,
      EV_AUP  = 2,
      EV_ADN  = 3,
      EV_BUP  = 4,
      EV_BDN  = 5
   } evt_idx_e;

   function automatic logic [REG_W-1:0] impl_bits();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         m[IRQ_LSB + i] = 1'b1;
         m[TRG_LSB + i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
   import pwm_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                              cnt_step,
   input  logic                              cnt_dir,
   input  logic [CNT_W-1:0]                  cnt,
   input  logic [CNT_W-1:0]                  load_val,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_vals,
   output logic [NUM_EVT-1:0]                evt_hit
);
   if (CNT_W < 1) begin : g_bad_width
      $error("pwm_evt_detect: CNT_W must be at least 1");
   end
   if (NUM_EVT != 2 + 2 * NUM_CMP) begin : g_bad_count
      $error("pwm_evt_detect: event count does not match comparator count");
   end

   assign evt_hit[EV_ZERO] = cnt_step & (cnt == '0);
   assign evt_hit[EV_LOAD] = cnt_step & (cnt == load_val);

   for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
      logic match;
      assign match                = cnt_step & (cnt == cmp_vals[c]);
      assign evt_hit[EV_AUP + 2*c] = match &  cnt_dir;
      assign evt_hit[EV_ADN + 2*c] = match & ~cnt_dir;
   end
endmodule

// File: rtl/pwm_evt_cfg_reg.sv
module pwm_evt_cfg_reg
   import pwm_evt_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int unsigned REG_OFS = 'h044
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   output logic [NUM_EVT-1:0] irq_mask,
   output logic [NUM_EVT-1:0] trig_mask
);
   localparam logic [REG_W-1:0]  IMPL_MASK = impl_bits();
   localparam logic [ADDR_W-1:0] OFS_A     = ADDR_W'(REG_OFS);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("pwm_evt_cfg_reg: ADDR_W out of range");
   end
   if (IRQ_LSB + NUM_EVT > TRG_LSB || TRG_LSB + NUM_EVT > REG_W) begin : g_bad_layout
      $error("pwm_evt_cfg_reg: enable fields overlap or overflow");
   end

   logic             hit;
   logic [REG_W-1:0] en_q;

   assign hit = (addr == OFS_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en && hit) en_q <= wr_data & IMPL_MASK;
         rd_data <= (rd_en && hit) ? en_q : '0;
      end
   end

   assign irq_mask  = en_q[IRQ_LSB +: NUM_EVT];
   assign trig_mask = en_q[TRG_LSB +: NUM_EVT];

   // R2: unimplemented bits never appear on the read port
   a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~IMPL_MASK) == '0);

   // R8: writes elsewhere leave the enables alone
   a_r8_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> ($stable(irq_mask) && $stable(trig_mask)));
endmodule

// File: rtl/pwm_evt_out.sv
module pwm_evt_out
   import pwm_evt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_hit,
   input  logic [NUM_EVT-1:0] irq_mask,
   input  logic [NUM_EVT-1:0] trig_mask,
   output logic               irq_pulse,
   output logic               adc_trig
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         adc_trig  <= 1'b0;
      end else begin
         irq_pulse <= |(evt_hit & irq_mask);
         adc_trig  <= |(evt_hit & trig_mask);
      end
   end

   // R6: no interrupt pulse without some interrupt enable set at the edge before
   a_r6_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(irq_mask != '0));
endmodule

// File: rtl/pwm_evt_route.sv
module pwm_evt_route
   import pwm_evt_pkg::*;
#(
   parameter int          CNT_W   = 16,
   parameter int          ADDR_W  = 12,
   parameter int unsigned REG_OFS = 'h044
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   input  logic              cnt_step,
   input  logic              cnt_dir,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [CNT_W-1:0]  cmpa_val,
   input  logic [CNT_W-1:0]  cmpb_val,
   output logic              irq_pulse,
   output logic              adc_trig
);
   if (REG_W != 32) begin : g_bad_reg
      $error("pwm_evt_route: register width must be 32");
   end

   logic [NUM_EVT-1:0]            evt_hit;
   logic [NUM_EVT-1:0]            irq_mask;
   logic [NUM_EVT-1:0]            trig_mask;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_vals;

   assign cmp_vals[0] = cmpa_val;
   assign cmp_vals[1] = cmpb_val;

   pwm_evt_cfg_reg #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data),
      .irq_mask(irq_mask), .trig_mask(trig_mask)
   );

   pwm_evt_detect #(.CNT_W(CNT_W)) u_det (
      .cnt_step(cnt_step), .cnt_dir(cnt_dir), .cnt(cnt), .load_val(load_val),
      .cmp_vals(cmp_vals), .evt_hit(evt_hit)
   );

   pwm_evt_out u_out (
      .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .irq_mask(irq_mask),
      .trig_mask(trig_mask), .irq_pulse(irq_pulse), .adc_trig(adc_trig)
   );

   // R7: a stalled counter produces nothing
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_step |=> (!adc_trig && !irq_pulse));

   // R3: zero reached with its trigger enable set gives a trigger next cycle
   a_r3_zero_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_step && cnt == '0 && trig_mask[EV_ZERO]) |=> adc_trig);

   // R3: load reached with its interrupt enable set gives an interrupt next cycle
   a_r3_load_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_step && cnt == load_val && irq_mask[EV_LOAD]) |=> irq_pulse);

   // R4: comparator B matched while counting down, with its trigger enabled
   a_r4_bdown_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_step && !cnt_dir && cnt == cmpb_val && trig_mask[EV_BDN]) |=> adc_trig);
endmodule

// File: tb/pwm_evt_route_tb.sv
module pwm_evt_route_tb;
   localparam int CNT_W  = 16;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] OFS = 12'h044;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wr_data = '0;
   logic [31:0]       rd_data;
   logic              cnt_step = 1'b0, cnt_dir = 1'b0;
   logic [CNT_W-1:0]  cnt = '0, load_val = '0, cmpa_val = '0, cmpb_val = '0;
   logic              irq_pulse, adc_trig;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   logic [31:0] mdl_en = '0;

   always #5 clk = ~clk;

   pwm_evt_route #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .cnt_step(cnt_step), .cnt_dir(cnt_dir),
      .cnt(cnt), .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
      .irq_pulse(irq_pulse), .adc_trig(adc_trig)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [5:0] events();
      logic [5:0] e;
      e = '0;
      if (cnt_step) begin
         e[0] = (cnt == 0);
         e[1] = (cnt == load_val);
         e[2] = (cnt == cmpa_val) &&  cnt_dir;
         e[3] = (cnt == cmpa_val) && !cnt_dir;
         e[4] = (cnt == cmpb_val) &&  cnt_dir;
         e[5] = (cnt == cmpb_val) && !cnt_dir;
      end
      return e;
   endfunction

   task automatic chk1(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // Drive at falling edge, then predict and check one edge later.
   task automatic cyc(string tag, logic w, logic r, logic [ADDR_W-1:0] a, logic [31:0] d,
                      logic st, logic dir, int c, int ld, int ca, int cb);
      logic [5:0] e;
      logic exp_irq, exp_trg;
      logic [31:0] exp_rd, nxt;
      wr_en = w; rd_en = r; addr = a; wr_data = d;
      cnt_step = st; cnt_dir = dir; cnt = CNT_W'(c);
      load_val = CNT_W'(ld); cmpa_val = CNT_W'(ca); cmpb_val = CNT_W'(cb);
      e = events();
      exp_irq = |(e & mdl_en[5:0]);
      exp_trg = |(e & mdl_en[13:8]);
      exp_rd  = (r && a == OFS) ? mdl_en : 32'h0;
      nxt     = (w && a == OFS) ? (d & 32'h0000_3F3F) : mdl_en;
      @(posedge clk);
      mdl_en = nxt;
      @(negedge clk);
      chk1(tag, "irq_pulse (R6)", {31'b0, irq_pulse}, {31'b0, exp_irq});
      chk1(tag, "adc_trig (R5)", {31'b0, adc_trig}, {31'b0, exp_trg});
      chk1(tag, "rd_data (R8)", rd_data, exp_rd);
   endtask

   task automatic wr(string tag, logic [ADDR_W-1:0] a, logic [31:0] d);
      cyc(tag, 1, 0, a, d, 0, 0, 5, 9, 9, 9);
   endtask

   task automatic rd(string tag, logic [ADDR_W-1:0] a);
      cyc(tag, 0, 1, a, 0, 0, 0, 5, 9, 9, 9);
   endtask

   task automatic ev(string tag, logic dir, int c, int ld, int ca, int cb);
      cyc(tag, 0, 0, OFS, 0, 1, dir, c, ld, ca, cb);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk1("R1", "irq_pulse", {31'b0, irq_pulse}, 0);
      chk1("R1", "adc_trig", {31'b0, adc_trig}, 0);
      chk1("R1", "rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1", OFS);
      chk1("R1", "reset readback", rd_data, 32'h0);
      ev("R1", 1, 0, 0, 0, 0);

      // R2: reserved bits
      wr("R2", OFS, 32'hFFFF_FFFF);
      rd("R2", OFS);
      chk1("R2", "all-ones readback", rd_data, 32'h0000_3F3F);
      wr("R2", OFS, 32'hFFFF_C0C0);
      rd("R2", OFS);
      chk1("R2", "reserved-only readback", rd_data, 32'h0);

      // R8: other addresses
      wr("R8", OFS, 32'h0000_0102);
      wr("R8", 12'h040, 32'h0000_3F3F);
      rd("R8", 12'h048);
      chk1("R8", "other-addr read", rd_data, 32'h0);
      rd("R8", OFS);
      chk1("R8", "unchanged after stray write", rd_data, 32'h0000_0102);

      // R3: zero -> trigger (bit 8), load -> irq (bit 1)
      ev("R3", 1, 0, 50, 7, 8);
      chk1("R3", "zero trig", {31'b0, adc_trig}, 1);
      chk1("R3", "zero no irq", {31'b0, irq_pulse}, 0);
      ev("R3", 0, 50, 50, 7, 8);
      chk1("R3", "load irq", {31'b0, irq_pulse}, 1);
      chk1("R3", "load no trig", {31'b0, adc_trig}, 0);

      // R4: direction-qualified compares
      wr("R4", OFS, 32'h0000_2004); // A-up irq (bit 2), B-down trig (bit 13)
      ev("R4", 1, 20, 99, 20, 30);
      chk1("R4", "A-up irq", {31'b0, irq_pulse}, 1);
      ev("R4", 0, 20, 99, 20, 30);
      chk1("R4", "A-down ignored", {31'b0, irq_pulse}, 0);
      ev("R4", 0, 30, 99, 20, 30);
      chk1("R4", "B-down trig", {31'b0, adc_trig}, 1);
      ev("R4", 1, 30, 99, 20, 30);
      chk1("R4", "B-up ignored", {31'b0, adc_trig}, 0);

      // R5: coincident events, one pulse per cycle
      wr("R5", OFS, 32'h0000_3F00);
      ev("R5", 1, 40, 40, 40, 40);
      chk1("R5", "coincident single pulse", {31'b0, adc_trig}, 1);
      ev("R5", 1, 41, 40, 40, 40);
      chk1("R5", "pulse ends", {31'b0, adc_trig}, 0);
      ev("R5", 1, 40, 40, 0, 0);
      ev("R5", 1, 40, 40, 0, 0);
      chk1("R5", "back-to-back steps", {31'b0, adc_trig}, 1);

      // R6: irq and trig independent
      wr("R6", OFS, 32'h0000_0820); // B-down irq (bit 5), A-down trig (bit 11)
      ev("R6", 0, 12, 99, 12, 13);
      chk1("R6", "A-down trig only", {30'b0, irq_pulse, adc_trig}, 32'h1);
      ev("R6", 0, 13, 99, 12, 13);
      chk1("R6", "B-down irq only", {30'b0, irq_pulse, adc_trig}, 32'h2);

      // R7: no step, no event
      wr("R7", OFS, 32'h0000_3F3F);
      cyc("R7", 0, 0, OFS, 0, 0, 1, 0, 0, 0, 0);
      chk1("R7", "stalled counter", {30'b0, irq_pulse, adc_trig}, 32'h0);

      // R9: write at the same edge as an event uses old enables
      wr("R9", OFS, 32'h0);
      cyc("R9", 1, 0, OFS, 32'h0000_0101, 1, 1, 0, 5, 5, 5);
      chk1("R9", "old enables used", {31'b0, adc_trig}, 0);
      ev("R9", 1, 0, 5, 5, 5);
      chk1("R9", "new enables used", {31'b0, adc_trig}, 1);

      // R10: read and write at one edge returns the old value
      cyc("R10", 1, 1, OFS, 32'h0000_0404, 0, 0, 1, 2, 3, 4);
      chk1("R10", "read before write", rd_data, 32'h0000_0101);
      rd("R10", OFS);
      chk1("R10", "write landed", rd_data, 32'h0000_0404);

      // Mixed random traffic, checked every cycle against the model
      for (int i = 0; i < 3000; i++) begin
         logic w, r, st, dir;
         logic [ADDR_W-1:0] a;
         w   = ($urandom_range(0, 9) == 0);
         r   = ($urandom_range(0, 4) == 0);
         a   = ($urandom_range(0, 3) == 0) ? 12'h040 : OFS;
         st  = ($urandom_range(0, 3) != 0);
         dir = 1'($urandom_range(0, 1));
         cyc("RND", w, r, a, $urandom(), st, dir,
             $urandom_range(0, 7), $urandom_range(0, 7),
             $urandom_range(0, 7), $urandom_range(0, 7));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule